// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge Port

This block sits between an interrupt distributor and one processor. It receives a level vector of pending sources from the distributor, ranks the eligible ones by a per-source priority byte, and raises an interrupt line toward the processor when the best candidate outranks everything the processor is already servicing. Sources 0 to 15 are software-generated; the distributor also supplies, for each of them, the number of the CPU that requested it.

Software talks to the block through a word-addressed register port with valid/ready request and response channels. The port holds an enable, a priority threshold, the per-source priority bytes, an acknowledge register and an end-of-interrupt register. Reading the acknowledge register returns the winning ID, marks it active, and sends a one-cycle take pulse to the distributor so it can clear its pending flag. Writing the returned value to the end-of-interrupt register retires the source. A read with no eligible candidate returns ID 1023 and leaves all state untouched. Request/response rules: a request transfers on a cycle with `req_valid` and `req_ready` both high. Writes complete on transfer and give no response. A read produces a response on the next cycle, and the response stays valid and unchanged until `rsp_ready` is seen high. While a response is waiting, `req_ready` is low.

Top module: `irq_cpu_port`

## Requirements
- R1: Bit 0 of the control word (word 0) gates the `irq` output; it resets to 0, and while it is 0 `irq` stays low.
- R2: The threshold word (word 1, bits [7:0]) resets to 0xF0; a source is eligible only while its priority byte is numerically below the threshold.
- R3: Word 2 (acknowledge) returns the ID of the eligible, not active, pending source with the numerically lowest priority byte in bits [9:0], the lowest ID on ties, and makes that source active so it is not offered again until retired.
- R4: For IDs 0 to 15 the acknowledge value also carries the requesting CPU number (from `sgi_src`, 3 bits per ID) in bits [12:10]; for other IDs bits [31:10] are zero.
- R5: With no candidate that would raise `irq`, an acknowledge read returns 1023, raises no take pulse and changes no state.
- R6: Writing an ID of 16 or above to word 3 (end-of-interrupt) retires that source if it is active; bits [31:10] are ignored for these IDs.
- R7: For IDs 0 to 15 an end-of-interrupt write retires the source only when the whole word equals the value that acknowledge returned; any other value has no effect.
- R8: `irq` is high when enabled and the best eligible candidate has a priority byte strictly below that of every active source; an active source of equal or better priority holds it low.
- R9: A read response stays valid with stable data until `rsp_ready`, and `req_ready` is low while a response waits.
- R10: Every acknowledge that returns a real ID drives `take_valid` high for exactly one cycle, together with the response, with `take_id` equal to that ID.
- R11: Priority bytes live at words 16 and up, four sources per word, source n in word 16+n/4 at bits [8*(n%4)+7 : 8*(n%4)]; they reset to 0 and read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response ready |
| rsp_data | output | 32 | Read response data |
| src_pend | input | 32 | Pending level per source from the distributor |
| sgi_src | input | 48 | Requesting CPU per software ID, 3 bits each |
| irq | output | 1 | Interrupt line to the processor |
| take_valid | output | 1 | One-cycle pulse: a source was acknowledged |
| take_id | output | 10 | ID of the acknowledged source |

## Verification
The hardest situation to reach is the interaction of several active sources with a changing pending set: a tie broken by ID, a pending source held back by an active one of equal priority, and the same pending source released once its priority byte is rewritten below that of the active one. The stimulus reaches it by programming priorities, acknowledging one source, rewriting the pending vector and priorities while it stays active, then retiring sources in turn. The other hard case is a software-ID retire written with the wrong CPU bits, which is observed by a follow-up acknowledge still returning 1023.

// File: rtl/icpu_pkg.sv
package icpu_pkg;
  localparam int ID_W        = 10;
  localparam int CPU_LSB     = 10;
  localparam int REG_CTRL    = 0;
  localparam int REG_PMASK   = 1;
  localparam int REG_ACK     = 2;
  localparam int REG_EOI     = 3;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;
  localparam logic [7:0]      PMASK_RESET = 8'hF0;
endpackage

// File: rtl/icpu_prio_pick.sv
// Chooses the requesting source with the numerically lowest priority byte;
// the strict compare keeps the lowest index on a tie.
module icpu_prio_pick #(
  parameter int N_SRC  = 32,
  parameter int PRIO_W = 8,
  parameter int IDW    = 10
) (
  input  logic [N_SRC-1:0]        req,
  input  logic [N_SRC*PRIO_W-1:0] prio,
  output logic                    found,
  output logic [IDW-1:0]          id,
  output logic [PRIO_W-1:0]       best
);
  always_comb begin
    found = 1'b0;
    id    = '0;
    best  = '1;
    for (int i = 0; i < N_SRC; i++) begin
      if (req[i] && (!found || prio[i*PRIO_W +: PRIO_W] < best)) begin
        found = 1'b1;
        best  = prio[i*PRIO_W +: PRIO_W];
        id    = IDW'(i);
      end
    end
  end
endmodule

// File: rtl/icpu_active.sv
// Active bit per source; software IDs remember the requesting CPU so that
// only the exact acknowledge word retires them.
module icpu_active #(
  parameter int N_SRC = 32,
  parameter int N_SGI = 16,
  parameter int CPU_W = 3,
  parameter int IDW   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [IDW-1:0]   set_id,
  input  logic [CPU_W-1:0] set_cpu,
  input  logic             clr_en,
  input  logic [31:0]      clr_word,
  output logic [N_SRC-1:0] active
);
  localparam int HI_LSB = IDW + CPU_W;

  logic [IDW-1:0] clr_id;
  assign clr_id = clr_word[IDW-1:0];

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic hit;
    if (i < N_SGI) begin : g_sgi
      logic [CPU_W-1:0] cpu_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cpu_q <= '0;
        else if (set_en && set_id == IDW'(i)) cpu_q <= set_cpu;
      end
      assign hit = (clr_id == IDW'(i)) &&
                   (clr_word[IDW +: CPU_W] == cpu_q) &&
                   (clr_word[31:HI_LSB] == '0);
    end else begin : g_hw
      assign hit = (clr_id == IDW'(i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             active[i] <= 1'b0;
      else if (set_en && set_id == IDW'(i))   active[i] <= 1'b1;
      else if (clr_en && hit)                 active[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_cpu_port.sv
module irq_cpu_port
  import icpu_pkg::*;
#(
  parameter int N_SRC     = 32,
  parameter int N_SGI     = 16,
  parameter int PRIO_W    = 8,
  parameter int CPU_W     = 3,
  parameter int ADDR_W    = 6,
  parameter int PRIO_BASE = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [31:0]            req_wdata,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [31:0]            rsp_data,
  input  logic [N_SRC-1:0]       src_pend,
  input  logic [N_SGI*CPU_W-1:0] sgi_src,
  output logic                   irq,
  output logic                   take_valid,
  output logic [ID_W-1:0]        take_id
);
  localparam int LANES      = 4;
  localparam int PRIO_WORDS = (N_SRC + LANES - 1) / LANES;

  // register state
  logic                    ctrl_en;
  logic [PRIO_W-1:0]       pmask_q;
  logic [N_SRC*PRIO_W-1:0] prio_q;
  logic [N_SRC-1:0]        active;

  // request decode
  logic req_fire, rd_fire, wr_fire, ack_rd, eoi_wr;
  assign req_ready = !rsp_valid;
  assign req_fire  = req_valid && req_ready;
  assign rd_fire   = req_fire && !req_write;
  assign wr_fire   = req_fire && req_write;
  assign ack_rd    = rd_fire && (req_addr == ADDR_W'(REG_ACK));
  assign eoi_wr    = wr_fire && (req_addr == ADDR_W'(REG_EOI));

  // candidate selection
  logic [N_SRC-1:0] elig;
  for (genvar i = 0; i < N_SRC; i++) begin : g_elig
    assign elig[i] = src_pend[i] && !active[i] &&
                     (prio_q[i*PRIO_W +: PRIO_W] < pmask_q);
  end

  logic              cand_found, run_found;
  logic [ID_W-1:0]   cand_id, run_id;
  logic [PRIO_W-1:0] cand_prio, run_prio;

  icpu_prio_pick #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .IDW(ID_W)) u_cand (
    .req(elig), .prio(prio_q), .found(cand_found), .id(cand_id), .best(cand_prio)
  );

  icpu_prio_pick #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .IDW(ID_W)) u_run (
    .req(active), .prio(prio_q), .found(run_found), .id(run_id), .best(run_prio)
  );

  logic beats_running;
  assign beats_running = !run_found || (cand_prio < run_prio);
  assign irq           = ctrl_en && cand_found && beats_running;

  // requesting CPU of the candidate, zero for hardware sources
  logic [CPU_W-1:0] cand_cpu;
  always_comb begin
    cand_cpu = '0;
    for (int i = 0; i < N_SGI; i++)
      if (cand_id == ID_W'(i)) cand_cpu = sgi_src[i*CPU_W +: CPU_W];
  end

  logic [31:0] ack_word;
  always_comb begin
    ack_word = 32'(cand_id);
    ack_word[CPU_LSB +: CPU_W] = cand_cpu;
  end

  logic ack_take;
  assign ack_take = ack_rd && irq;

  icpu_active #(.N_SRC(N_SRC), .N_SGI(N_SGI), .CPU_W(CPU_W), .IDW(ID_W)) u_act (
    .clk(clk), .rst_n(rst_n),
    .set_en(ack_take), .set_id(cand_id), .set_cpu(cand_cpu),
    .clr_en(eoi_wr), .clr_word(req_wdata),
    .active(active)
  );

  // control and threshold registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en <= 1'b0;
      pmask_q <= PRIO_W'(PMASK_RESET);
    end else if (wr_fire) begin
      if (req_addr == ADDR_W'(REG_CTRL))  ctrl_en <= req_wdata[0];
      if (req_addr == ADDR_W'(REG_PMASK)) pmask_q <= req_wdata[PRIO_W-1:0];
    end
  end

  // priority bytes, four sources per word
  for (genvar i = 0; i < N_SRC; i++) begin : g_prio
    localparam int WORD = PRIO_BASE + i / LANES;
    localparam int LANE = i % LANES;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        prio_q[i*PRIO_W +: PRIO_W] <= '0;
      else if (wr_fire && req_addr == ADDR_W'(WORD))
        prio_q[i*PRIO_W +: PRIO_W] <= req_wdata[LANE*8 +: PRIO_W];
    end
  end

  // read mux
  logic [31:0] rd_data;
  always_comb begin
    rd_data = '0;
    if (req_addr == ADDR_W'(REG_CTRL))  rd_data[0] = ctrl_en;
    if (req_addr == ADDR_W'(REG_PMASK)) rd_data[PRIO_W-1:0] = pmask_q;
    if (req_addr == ADDR_W'(REG_ACK))   rd_data = irq ? ack_word : 32'(SPURIOUS_ID);
    for (int w = 0; w < PRIO_WORDS; w++) begin
      if (req_addr == ADDR_W'(PRIO_BASE + w)) begin
        for (int b = 0; b < LANES; b++)
          if (w * LANES + b < N_SRC)
            rd_data[b*8 +: PRIO_W] = prio_q[(w*LANES+b)*PRIO_W +: PRIO_W];
      end
    end
  end

  // response and take pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      take_valid <= 1'b0;
      take_id    <= '0;
    end else begin
      take_valid <= ack_take;
      if (ack_take) take_id <= cand_id;
      if (rd_fire) begin
        rsp_valid <= 1'b1;
        rsp_data  <= rd_data;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/icpu_checks.sv
module icpu_checks
  import icpu_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [31:0]       rsp_data,
  input logic [N_SRC-1:0]  src_pend,
  input logic              irq,
  input logic              take_valid,
  input logic [ID_W-1:0]   take_id
);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> !req_ready);

  p_take_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid |-> rsp_valid && rsp_data[ID_W-1:0] == take_id);

  p_take_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid |-> $past(req_valid && req_ready && !req_write &&
                         req_addr == ADDR_W'(REG_ACK)));

  p_take_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid |=> !take_valid);

  p_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) && rsp_data[ID_W-1:0] == SPURIOUS_ID |-> !take_valid);

  p_irq_needs_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> |src_pend);
endmodule

bind irq_cpu_port icpu_checks #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_data(rsp_data), .src_pend(src_pend),
  .irq(irq), .take_valid(take_valid), .take_id(take_id)
);

// File: tb/tb_irq_cpu_port.sv
module tb_irq_cpu_port;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [5:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_data;
  logic [31:0] src_pend = '0;
  logic [47:0] sgi_src = '0;
  logic        irq;
  logic        take_valid;
  logic [9:0]  take_id;

  int n_tests = 0;
  int n_fail  = 0;
  logic        seen_take;
  logic [9:0]  seen_id;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_cpu_port dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .src_pend(src_pend), .sgi_src(sgi_src), .irq(irq),
    .take_valid(take_valid), .take_id(take_id)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input int addr, input logic [31:0] data);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 6'(addr); req_wdata = data;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(input int addr, output logic [31:0] data);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 6'(addr);
    @(negedge clk);
    req_valid = 1'b0;
    data      = rsp_data;
    seen_take = take_valid;
    seen_id   = take_id;
  endtask

  task automatic set_prio(input int src, input logic [7:0] val);
    logic [31:0] w;
    bus_read(16 + src / 4, w);
    w[(src % 4) * 8 +: 8] = val;
    bus_write(16 + src / 4, w);
  endtask

  task automatic set_pend(input logic [31:0] v);
    @(negedge clk);
    src_pend = v;
    #1;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk(irq == 1'b0, "R1 irq low after reset", 32'(irq), 0);
    bus_read(0, d);  chk(d == 0, "R1 control resets to 0", d, 0);
    bus_read(1, d);  chk(d == 32'hF0, "R2 threshold resets to F0", d, 32'hF0);
    bus_read(20, d); chk(d == 0, "R11 priority word resets to 0", d, 0);
  endtask

  task automatic t_enable;
    set_pend(32'h1 << 20);
    chk(irq == 1'b0, "R1 irq gated while disabled", 32'(irq), 0);
    bus_write(0, 32'h1);
    #1;
    chk(irq == 1'b1, "R1 irq after enable", 32'(irq), 1);
    set_pend(0);
  endtask

  task automatic t_prio_rw;
    logic [31:0] d;
    bus_write(21, 32'h44332211);
    bus_read(21, d);
    chk(d == 32'h44332211, "R11 priority word readback", d, 32'h44332211);
    bus_write(21, 32'h0);
  endtask

  task automatic t_arbitrate;
    logic [31:0] d;
    set_prio(20, 8'h40); set_prio(25, 8'h20); set_prio(30, 8'h20);
    set_pend((32'h1 << 20) | (32'h1 << 25) | (32'h1 << 30));
    bus_read(2, d);
    chk(d == 25, "R3 best priority, lowest ID on tie", d, 25);
    chk(seen_take && seen_id == 25, "R10 take pulse with ID", 32'(seen_id), 25);
    @(negedge clk);
    chk(take_valid == 1'b0, "R10 take lasts one cycle", 32'(take_valid), 0);
    set_pend((32'h1 << 20) | (32'h1 << 30));
    chk(irq == 1'b0, "R8 equal-priority active holds irq", 32'(irq), 0);
    bus_write(3, 32'hFFFFFC00 | 32'd25);
    #1;
    chk(irq == 1'b1, "R6 retire releases irq", 32'(irq), 1);
    bus_read(2, d);
    chk(d == 30, "R3 next candidate after retire", d, 30);
    #1;
    chk(irq == 1'b0, "R8 lower priority held off", 32'(irq), 0);
    set_prio(20, 8'h10);
    #1;
    chk(irq == 1'b1, "R8 higher priority signalled over active", 32'(irq), 1);
    bus_read(2, d);
    chk(d == 20, "R3 acknowledge returns higher one", d, 20);
    bus_write(3, 20); bus_write(3, 30);
    set_pend(0);
  endtask

  task automatic t_threshold;
    logic [31:0] d;
    set_prio(17, 8'hF0);
    set_pend(32'h1 << 17);
    chk(irq == 1'b0, "R2 priority at threshold not signalled", 32'(irq), 0);
    bus_read(2, d);
    chk(d == 1023, "R5 spurious ID", d, 1023);
    chk(seen_take == 1'b0, "R5 no take on spurious", 32'(seen_take), 0);
    bus_write(1, 32'hFF);
    #1;
    chk(irq == 1'b1, "R5 R2 source still offered after spurious", 32'(irq), 1);
    bus_read(2, d);
    chk(d == 17, "R2 acknowledged under raised threshold", d, 17);
    bus_write(3, 17);
    set_pend(0);
  endtask

  task automatic t_sgi;
    logic [31:0] d;
    sgi_src[3*3 +: 3] = 3'd5;
    set_pend(32'h1 << 3);
    bus_read(2, d);
    chk(d == 32'h1403, "R4 software ID carries CPU bits", d, 32'h1403);
    bus_write(3, 32'h3);
    bus_read(2, d);
    chk(d == 1023, "R7 wrong CPU bits leave source active", d, 1023);
    bus_write(3, 32'h1403);
    bus_read(2, d);
    chk(d == 32'h1403, "R7 exact word retires source", d, 32'h1403);
    bus_write(3, 32'h1403);
    set_pend(0);
  endtask

  task automatic t_backpressure;
    logic [31:0] first;
    @(negedge clk);
    rsp_ready = 1'b0;
    bus_read(1, first);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_data == first, "R9 response held", rsp_data, first);
      chk(req_ready == 1'b0, "R9 request stalled", 32'(req_ready), 0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R9 response drained", 32'(rsp_valid), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_enable();
    t_prio_rw();
    t_arbitrate();
    t_threshold();
    t_sgi();
    t_backpressure();
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule